// File: doc/BRIEF.md
# Pixel Hit Time Stamper

This block is the digital tail of one pixel. It watches the pixel's discriminator output and turns each accepted hit into one fixed-width record for the column readout. The arrival time is split in two parts. The coarse part is a time stamp shared across the chip, taken from an input bus. The fine part counts cycles of a clock that runs 16 times faster than the sync clock. This counter starts on the hit's leading edge and stops at the next sync-clock edge. While the discriminator stays high, a time-over-threshold (ToT) counter counts sync periods.

The whole block runs on the fast clock. A one-cycle strobe, `sync_stb_i`, marks the fast-clock edge that coincides with a sync-clock edge. The time-stamp bus is expected to stay constant between two strobes. The downstream arrival time is `ts*16 - fine`. A third acquisition mode counts hits and integrates ToT over a shutter window instead. It reports once when the shutter closes. A record stays valid until the readout acknowledges it, and the pixel takes no new hit while a record waits.

Top module: `pix_hit_stamper`

## Requirements
- R1: While `rst_n` is low and after its release, `rec_valid_o` is 0, `busy_o` is 0 and `rec_data_o` is all zeros.
- R2: A hit is a rising edge of `disc_i`. When a hit is registered k fast edges before a strobed edge, the fine field is k, for k from 0 to 15. A hit registered on the strobed edge itself gives 0.
- R3: The time-stamp field holds the value of `ts_i` at the strobed edge that ends the fine count.
- R4: Mode 2'b00 (arrival time with ToT) builds the record as fine in [43:40], ToT in [39:30], time stamp in [29:16] and `pix_addr_i` in [15:0]. ToT is the number of strobed edges at which `disc_i` is high, starting with the edge that stops the fine count. The record is formed at the first edge that samples `disc_i` low, or at the stopping edge if `disc_i` is already low there.
- R5: Mode 2'b01 (arrival time only; 2'b11 acts the same) forms the record at the edge that stops the fine count, with the ToT field zero.
- R6: The counters saturate at their maximum and never wrap. The fine count holds at 15 when no strobe arrives, and ToT holds at 1023.
- R7: While `rec_valid_o` is high, a new hit is ignored, `rec_data_o` does not change, and `busy_o` is high.
- R8: When `rd_ack_i` is high at an edge where `rec_valid_o` is high, `rec_valid_o` is low from the next cycle on.
- R9: In mode 2'b00, after a record is formed the pixel ignores hits and holds `busy_o` high for `HOLD_SYNC` strobed edges (default 28).
- R10: Mode 2'b10 (event count with integral ToT) clears both counters on a rising edge of `shutter_i`. While the shutter stays open, it counts hits in the event count and strobed edges with `disc_i` high in the integral. When the shutter closes, it forms a record with zero in [43:40], the event count in [39:30], the integral in [29:16] and the address in [15:0].
- R11: The event count saturates at 1023 and the integral at 16383.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, 16 times the sync rate |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Acquisition mode, static while acquiring |
| disc_i | input | 1 | Discriminator output |
| shutter_i | input | 1 | Shutter window for the counting mode |
| sync_stb_i | input | 1 | High on the fast edge that is a sync-clock edge |
| ts_i | input | TS_W | Shared coarse time stamp |
| pix_addr_i | input | ADDR_W | Pixel address placed in every record |
| rd_ack_i | input | 1 | Readout acknowledge of the pending record |
| rec_valid_o | output | 1 | A record is pending |
| rec_data_o | output | REC_W | Hit or frame record |
| busy_o | output | 1 | Pixel cannot accept a hit |

## Verification
Two pairs of events can land on the same edge, and the bench provokes both. The first pair is a hit's leading edge and a sync strobe. The bench raises the discriminator so that it is registered exactly on a strobed edge, then expects a fine count of 0 and a ToT that already includes that edge. The second pair is an acknowledge and a new hit edge. The bench drives both in the same cycle. The record must clear on the next cycle, and no new record may appear afterwards, because the hit arrived while the old record was still pending.

// File: rtl/pix_pkg.sv
// Shared types for the pixel hit stamper.
// Assumes: mode is held static while an acquisition is running.
package pix_pkg;
    typedef enum logic [1:0] {
        MODE_TOA_TOT = 2'b00,
        MODE_TOA     = 2'b01,
        MODE_COUNT   = 2'b10,
        MODE_TOA_ALT = 2'b11
    } acq_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_FINE = 2'b01,
        ST_TOT  = 2'b10
    } toa_state_e;
endpackage

// File: rtl/pix_in_reg.sv
// Registers the discriminator and shutter levels and derives their edges.
// Assumes: both inputs are already synchronous to clk.
module pix_in_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic disc_i,
    input  logic shutter_i,
    output logic hit_edge_o,
    output logic shut_q_o,
    output logic shut_open_o,
    output logic shut_close_o
);
    logic disc_q;
    logic shut_q;

    // Purpose: keep last cycle's level of both inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disc_q <= 1'b0;
            shut_q <= 1'b0;
        end else begin
            disc_q <= disc_i;
            shut_q <= shutter_i;
        end
    end

    // Purpose: edge strobes from current versus previous level.
    always_comb begin
        hit_edge_o   = disc_i & ~disc_q;
        shut_open_o  = shutter_i & ~shut_q;
        shut_close_o = ~shutter_i & shut_q;
        shut_q_o     = shut_q;
    end
endmodule

// File: rtl/pix_toa_engine.sv
// Arrival-time and ToT measurement for one pixel.
// A hit starts a fine counter, which stops at the next strobed edge,
// where the coarse stamp is taken. In ToT mode the engine then counts
// strobed edges while the discriminator is high. The end of a measurement
// is reported as a registered pulse with stable fields.
// Assumes: arm_i is low while the record register is occupied.
module pix_toa_engine #(
    parameter int FINE_W    = 4,
    parameter int TS_W      = 14,
    parameter int TOT_W     = 10,
    parameter int HOLD_SYNC = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              tot_mode_i,
    input  logic              hit_edge_i,
    input  logic              disc_i,
    input  logic              sync_stb_i,
    input  logic [TS_W-1:0]   ts_i,
    output logic              done_o,
    output logic [FINE_W-1:0] fine_o,
    output logic [TS_W-1:0]   ts_o,
    output logic [TOT_W-1:0]  tot_o,
    output logic              busy_o
);
    import pix_pkg::*;

    localparam int HOLD_W = $clog2(HOLD_SYNC + 1);
    localparam logic [FINE_W-1:0] FINE_MAX = '1;
    localparam logic [TOT_W-1:0]  TOT_MAX  = '1;
    localparam logic [HOLD_W-1:0] HOLD_LD  = HOLD_W'(HOLD_SYNC);

    toa_state_e        st;
    logic [FINE_W-1:0] fine_q;
    logic [TS_W-1:0]   ts_q;
    logic [TOT_W-1:0]  tot_q;
    logic [HOLD_W-1:0] hold_q;
    logic              done_q;
    logic              accept;

    // Purpose: a hit is taken only when idle, reported and out of dead time.
    assign accept = arm_i && (st == ST_IDLE) && !done_q && (hold_q == '0);

    // Purpose: measurement state machine, counters and dead-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            fine_q <= '0;
            ts_q   <= '0;
            tot_q  <= '0;
            hold_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (sync_stb_i && hold_q != '0) begin
                hold_q <= hold_q - 1'b1;
            end
            case (st)
                ST_IDLE: begin
                    if (accept && hit_edge_i) begin
                        tot_q <= '0;
                        if (sync_stb_i) begin
                            fine_q <= '0;
                            ts_q   <= ts_i;
                            if (tot_mode_i) begin
                                tot_q <= TOT_W'(1);
                                st    <= ST_TOT;
                            end else begin
                                done_q <= 1'b1;
                            end
                        end else begin
                            fine_q <= FINE_W'(1);
                            st     <= ST_FINE;
                        end
                    end
                end
                ST_FINE: begin
                    if (sync_stb_i) begin
                        ts_q <= ts_i;
                        if (tot_mode_i && disc_i) begin
                            tot_q <= TOT_W'(1);
                            st    <= ST_TOT;
                        end else begin
                            done_q <= 1'b1;
                            st     <= ST_IDLE;
                            if (tot_mode_i) begin
                                hold_q <= HOLD_LD;
                            end
                        end
                    end else if (fine_q != FINE_MAX) begin
                        fine_q <= fine_q + 1'b1;
                    end
                end
                ST_TOT: begin
                    if (!disc_i) begin
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                        hold_q <= HOLD_LD;
                    end else if (sync_stb_i && tot_q != TOT_MAX) begin
                        tot_q <= tot_q + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Purpose: drive the result fields and the busy indication.
    always_comb begin
        done_o = done_q;
        fine_o = fine_q;
        ts_o   = ts_q;
        tot_o  = tot_q;
        busy_o = (st != ST_IDLE) || done_q || (hold_q != '0);
    end

    // R6: the fine value is frozen once ToT counting has begun
    a_r6_fine_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TOT) |=> $stable(fine_q));

    // R6: ToT stays at its ceiling instead of wrapping
    a_r6_tot_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TOT && tot_q == TOT_MAX) |=> (tot_q == TOT_MAX));

    // R9: no measurement starts during dead time
    a_r9_dead_time: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && hold_q != '0) |=> (st == ST_IDLE));

    // R5: only the ToT mode can enter the ToT state
    a_r5_no_tot_state: assert property (@(posedge clk) disable iff (!rst_n)
        (!tot_mode_i && st != ST_TOT) |=> (st != ST_TOT));
endmodule

// File: rtl/pix_frame_counter.sv
// Event count and integral ToT over one shutter window.
// Clears on shutter open and reports when the shutter closes.
// Assumes: enable_i is high only in the counting mode.
module pix_frame_counter #(
    parameter int EVT_W  = 10,
    parameter int ITOT_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              shutter_i,
    input  logic              shut_q_i,
    input  logic              shut_open_i,
    input  logic              shut_close_i,
    input  logic              hit_edge_i,
    input  logic              disc_i,
    input  logic              sync_stb_i,
    input  logic              pending_i,
    output logic              done_o,
    output logic [EVT_W-1:0]  evt_o,
    output logic [ITOT_W-1:0] itot_o
);
    localparam logic [EVT_W-1:0]  EVT_MAX  = '1;
    localparam logic [ITOT_W-1:0] ITOT_MAX = '1;

    logic [EVT_W-1:0]  evt_q;
    logic [ITOT_W-1:0] itot_q;
    logic              window;

    // Purpose: counting is active while the shutter stays open.
    assign window = shutter_i && shut_q_i;

    // Purpose: clear on open, then saturating accumulation inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q  <= '0;
            itot_q <= '0;
        end else if (enable_i) begin
            if (shut_open_i) begin
                evt_q  <= '0;
                itot_q <= '0;
            end else if (window) begin
                if (hit_edge_i && evt_q != EVT_MAX) begin
                    evt_q <= evt_q + 1'b1;
                end
                if (sync_stb_i && disc_i && itot_q != ITOT_MAX) begin
                    itot_q <= itot_q + 1'b1;
                end
            end
        end
    end

    // Purpose: report request on shutter close when the record slot is free.
    always_comb begin
        done_o = enable_i && shut_close_i && !pending_i;
        evt_o  = evt_q;
        itot_o = itot_q;
    end

    // R10: both counters are zero after a shutter opening
    a_r10_clear_on_open: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && shut_open_i) |=> (evt_q == '0 && itot_q == '0));

    // R11: event count holds at its ceiling
    a_r11_evt_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q == EVT_MAX && !shut_open_i) |=> (evt_q == EVT_MAX));

    // R11: integral holds at its ceiling
    a_r11_itot_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (itot_q == ITOT_MAX && !shut_open_i) |=> (itot_q == ITOT_MAX));
endmodule

// File: rtl/pix_hit_stamper.sv
// Per-pixel hit stamper top: input edge logic, arrival/ToT engine,
// shutter-window counter and the single record register toward readout.
// Assumes: clk is 16x the sync clock and sync_stb_i marks sync edges.
module pix_hit_stamper #(
    parameter int FINE_W    = 4,
    parameter int TS_W      = 14,
    parameter int TOT_W     = 10,
    parameter int EVT_W     = 10,
    parameter int ITOT_W    = 14,
    parameter int ADDR_W    = 16,
    parameter int HOLD_SYNC = 28,
    localparam int REC_W    = FINE_W + TOT_W + TS_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              disc_i,
    input  logic              shutter_i,
    input  logic              sync_stb_i,
    input  logic [TS_W-1:0]   ts_i,
    input  logic [ADDR_W-1:0] pix_addr_i,
    input  logic              rd_ack_i,
    output logic              rec_valid_o,
    output logic [REC_W-1:0]  rec_data_o,
    output logic              busy_o
);
    import pix_pkg::*;

    localparam int CNT_W = EVT_W + ITOT_W + ADDR_W;

    acq_mode_e         mode;
    logic              hit_edge, shut_q, shut_open, shut_close;
    logic              toa_done, toa_busy, cnt_done;
    logic [FINE_W-1:0] fine;
    logic [TS_W-1:0]   ts;
    logic [TOT_W-1:0]  tot;
    logic [EVT_W-1:0]  evt;
    logic [ITOT_W-1:0] itot;
    logic [REC_W-1:0]  toa_rec, cnt_rec;
    logic              rec_valid;
    logic [REC_W-1:0]  rec_data;

    assign mode = acq_mode_e'(mode_i);

    pix_in_reg u_in (
        .clk          (clk),
        .rst_n        (rst_n),
        .disc_i       (disc_i),
        .shutter_i    (shutter_i),
        .hit_edge_o   (hit_edge),
        .shut_q_o     (shut_q),
        .shut_open_o  (shut_open),
        .shut_close_o (shut_close)
    );

    pix_toa_engine #(
        .FINE_W    (FINE_W),
        .TS_W      (TS_W),
        .TOT_W     (TOT_W),
        .HOLD_SYNC (HOLD_SYNC)
    ) u_toa (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      ((mode != MODE_COUNT) && !rec_valid),
        .tot_mode_i (mode == MODE_TOA_TOT),
        .hit_edge_i (hit_edge),
        .disc_i     (disc_i),
        .sync_stb_i (sync_stb_i),
        .ts_i       (ts_i),
        .done_o     (toa_done),
        .fine_o     (fine),
        .ts_o       (ts),
        .tot_o      (tot),
        .busy_o     (toa_busy)
    );

    pix_frame_counter #(
        .EVT_W  (EVT_W),
        .ITOT_W (ITOT_W)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (mode == MODE_COUNT),
        .shutter_i    (shutter_i),
        .shut_q_i     (shut_q),
        .shut_open_i  (shut_open),
        .shut_close_i (shut_close),
        .hit_edge_i   (hit_edge),
        .disc_i       (disc_i),
        .sync_stb_i   (sync_stb_i),
        .pending_i    (rec_valid),
        .done_o       (cnt_done),
        .evt_o        (evt),
        .itot_o       (itot)
    );

    // Purpose: assemble both record layouts, count layout zero-extended.
    always_comb begin
        toa_rec = {fine, tot, ts, pix_addr_i};
        cnt_rec = '0;
        cnt_rec[CNT_W-1:0] = {evt, itot, pix_addr_i};
    end

    // Purpose: single pending-record register with acknowledge release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid <= 1'b0;
            rec_data  <= '0;
        end else if (toa_done && !rec_valid) begin
            rec_valid <= 1'b1;
            rec_data  <= toa_rec;
        end else if (cnt_done) begin
            rec_valid <= 1'b1;
            rec_data  <= cnt_rec;
        end else if (rec_valid && rd_ack_i) begin
            rec_valid <= 1'b0;
        end
    end

    // Purpose: drive outputs.
    always_comb begin
        rec_valid_o = rec_valid;
        rec_data_o  = rec_data;
        busy_o      = rec_valid || toa_busy;
    end

    // R8: acknowledge releases the record on the following cycle
    a_r8_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rd_ack_i) |=> !rec_valid);

    // R7: an unacknowledged record stays valid and unchanged
    a_r7_record_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rd_ack_i) |=> (rec_valid && $stable(rec_data)));

    // R7: the engine never finishes while a record is pending
    a_r7_no_done_pending: assert property (@(posedge clk) disable iff (!rst_n)
        toa_done |-> !rec_valid);

    // R7: busy is reported whenever a record waits
    a_r7_busy_pending: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> busy_o);
endmodule

// File: tb/sim_pix_hit_stamper.sv
`timescale 1ns/1ps
module sim_pix_hit_stamper;
    localparam logic [15:0] ADDR = 16'hA5C3;
    localparam int HOLD = 28;

    // Vector: mode(2) k(4) n(11) expected fine(4) expected tot(10)
    localparam int NV = 8;
    localparam logic [30:0] VEC [NV] = '{
        {2'd0, 4'd0,  11'd1,  4'd0,  10'd1},
        {2'd0, 4'd5,  11'd3,  4'd5,  10'd3},
        {2'd0, 4'd15, 11'd2,  4'd15, 10'd2},
        {2'd0, 4'd7,  11'd0,  4'd7,  10'd0},
        {2'd0, 4'd1,  11'd10, 4'd1,  10'd10},
        {2'd1, 4'd3,  11'd2,  4'd3,  10'd0},
        {2'd1, 4'd0,  11'd1,  4'd0,  10'd0},
        {2'd1, 4'd9,  11'd0,  4'd9,  10'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        disc = 1'b0;
    logic        shutter = 1'b0;
    logic        sync_stb = 1'b0;
    logic [13:0] ts_in = 14'h3FF8;
    logic        rd_ack = 1'b0;
    logic        rec_valid;
    logic [43:0] rec_data;
    logic        busy;

    logic [3:0]  phase = 4'd15;
    logic        sync_en = 1'b1;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    pix_hit_stamper u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .disc_i      (disc),
        .shutter_i   (shutter),
        .sync_stb_i  (sync_stb),
        .ts_i        (ts_in),
        .pix_addr_i  (ADDR),
        .rd_ack_i    (rd_ack),
        .rec_valid_o (rec_valid),
        .rec_data_o  (rec_data),
        .busy_o      (busy)
    );

    // Sync strobe every 16 cycles; stamp advances just after a strobed edge.
    initial begin
        forever begin
            @(negedge clk);
            phase    = phase + 4'd1;
            sync_stb = sync_en && (phase == 4'd15);
            if (phase == 4'd0) ts_in = ts_in + 14'd1;
        end
    end

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        report();
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_phase(input logic [3:0] p);
        step();
        while (phase != p) step();
    endtask

    // Hit registered k edges before a strobed edge; high for n strobed edges.
    task automatic pulse(input int k, input int n, output logic [13:0] ts_exp);
        wait_phase(4'(15 - k));
        disc = 1'b1;
        ts_exp = ts_in;
        if (n == 0) begin
            step();
        end else begin
            repeat (k + 16 * (n - 1) + 1) step();
        end
        disc = 1'b0;
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 64 && !rec_valid; i++) step();
    endtask

    task automatic ack_check();
        chk("R8 valid before ack", 64'(rec_valid), 64'd1);
        rd_ack = 1'b1;
        step();
        rd_ack = 1'b0;
        chk("R8 valid after ack", 64'(rec_valid), 64'd0);
    endtask

    function automatic logic [43:0] toa_exp(logic [3:0] f, logic [9:0] t, logic [13:0] s);
        return {f, t, s, ADDR};
    endfunction

    initial begin
        logic [13:0] tsx;
        logic [43:0] held;
        int ie;

        // R1: reset state
        repeat (4) step();
        chk("R1 valid in reset", 64'(rec_valid), 64'd0);
        chk("R1 busy in reset", 64'(busy), 64'd0);
        chk("R1 data in reset", 64'(rec_data), 64'd0);
        rst_n = 1'b1;
        repeat (3) step();
        chk("R1 valid after reset", 64'(rec_valid), 64'd0);

        // R2 R3 R4 R5: table of arrival/ToT vectors
        for (int v = 0; v < NV; v++) begin
            mode = VEC[v][30:29];
            pulse(int'(VEC[v][28:25]), int'(VEC[v][24:14]), tsx);
            wait_valid();
            chk("R2 R3 R4 R5 record", 64'(rec_data),
                64'(toa_exp(VEC[v][13:10], VEC[v][9:0], tsx)));
            ack_check();
            repeat ((HOLD + 2) * 16) step();
        end

        // R7: hit ignored while a record is pending
        mode = 2'd1;
        pulse(4, 1, tsx);
        wait_valid();
        chk("R7 first record", 64'(rec_data), 64'(toa_exp(4'd4, 10'd0, tsx)));
        held = rec_data;
        pulse(9, 1, tsx);
        repeat (40) step();
        chk("R7 still valid", 64'(rec_valid), 64'd1);
        chk("R7 data held", 64'(rec_data), 64'(held));
        chk("R7 busy while pending", 64'(busy), 64'd1);

        // R7 R8: acknowledge and new hit in the same cycle
        rd_ack = 1'b1;
        disc = 1'b1;
        step();
        rd_ack = 1'b0;
        chk("R8 cleared with coincident hit", 64'(rec_valid), 64'd0);
        repeat (40) step();
        disc = 1'b0;
        repeat (40) step();
        chk("R7 coincident hit ignored", 64'(rec_valid), 64'd0);

        // R6: fine count saturates when the strobe is missing
        wait_phase(4'd3);
        sync_en = 1'b0;
        step();
        disc = 1'b1;
        repeat (40) step();
        sync_en = 1'b1;
        step();
        wait_phase(4'd15);
        tsx = ts_in;
        wait_valid();
        chk("R6 fine saturates", 64'(rec_data), 64'(toa_exp(4'd15, 10'd0, tsx)));
        disc = 1'b0;
        ack_check();

        // R6: ToT saturates
        mode = 2'd0;
        pulse(2, 1030, tsx);
        wait_valid();
        chk("R6 tot saturates", 64'(rec_data), 64'(toa_exp(4'd2, 10'd1023, tsx)));
        ack_check();
        repeat ((HOLD + 2) * 16) step();

        // R9: dead time after a ToT record
        pulse(2, 1, tsx);
        wait_valid();
        chk("R9 record before dead time", 64'(rec_data), 64'(toa_exp(4'd2, 10'd1, tsx)));
        ack_check();
        repeat (5 * 16) step();
        pulse(3, 1, tsx);
        repeat (40) step();
        chk("R9 hit ignored in dead time", 64'(rec_valid), 64'd0);
        chk("R9 busy in dead time", 64'(busy), 64'd1);
        repeat ((HOLD + 2) * 16) step();
        chk("R9 busy released", 64'(busy), 64'd0);
        pulse(5, 2, tsx);
        wait_valid();
        chk("R9 hit accepted after dead time", 64'(rec_data), 64'(toa_exp(4'd5, 10'd2, tsx)));
        ack_check();

        // R10: counting mode over one shutter window
        mode = 2'd2;
        step();
        shutter = 1'b1;
        repeat (3) step();
        pulse(3, 2, tsx);
        pulse(0, 1, tsx);
        pulse(6, 0, tsx);
        repeat (3) step();
        shutter = 1'b0;
        step();
        chk("R10 frame record", 64'(rec_data), 64'({4'd0, 10'd3, 14'd3, ADDR}));
        ack_check();

        // R10: reopening clears the counters
        shutter = 1'b1;
        repeat (3) step();
        shutter = 1'b0;
        step();
        chk("R10 cleared on open", 64'(rec_data), 64'({4'd0, 10'd0, 14'd0, ADDR}));
        ack_check();

        // R11: event count saturation
        shutter = 1'b1;
        repeat (2) step();
        ie = 0;
        for (int i = 0; i < 1030; i++) begin
            step();
            disc = 1'b1;
            if (phase == 4'd15) ie++;
            step();
            disc = 1'b0;
        end
        step();
        shutter = 1'b0;
        step();
        chk("R11 event saturation", 64'(rec_data), 64'({4'd0, 10'd1023, 14'(ie), ADDR}));
        ack_check();

        report();
    end
endmodule